// File: doc/BRIEF.md
# Segment-Mapped Address Translator

This block sits at the front of a memory management unit. For each access it decides between three routes. When translation is globally off, the address passes through unchanged. Privileged accesses to an enabled segment are remapped directly. Every other access is marked for the page-table path. The top four bits of the 32-bit virtual address select one of sixteen segments. Each segment owns a 4-bit physical base, and the sixteen bases are packed as nibbles into a low and a high 32-bit base register.

A directly mapped access never needs a page walk and always carries full read, write and execute rights. The caller reads the segment-hit flag to skip the walk. It reads the page-request flag to start one. The block itself holds no page tables. It is combinational by default, and a parameter adds one output register stage.

Top module: `seg_xlate_top`

## Requirements
- R1: Translation is on when either bit of the 2-bit `xlat_cfg` input is 1. When both bits are 0, `paddr` equals `vaddr`, `full_perm` is 1, and `seg_hit` and `page_req` are 0.
- R2: The segment number is `vaddr[31:28]`.
- R3: When translation is on, an access is segment-mapped (`seg_hit`=1, `page_req`=0) only when `seg_enable[segment]` is 1 and `user_mode` is 0. `seg_hit` and `page_req` are never both 1.
- R4: Segments 0 to 7 take their base from `base_lo`. Segments 8 to 15 take it from `base_hi`.
- R5: Within the chosen register, the base is the nibble at bits [4i+3:4i], where i is the segment number AND 7.
- R6: A segment-mapped access gives `paddr` = {base nibble, `vaddr[27:0]`}.
- R7: A segment-mapped access has `full_perm` = 1.
- R8: When translation is on and the access is from user mode or targets a segment whose enable bit is 0, the outputs are `page_req`=1, `seg_hit`=0, `full_perm`=0 and `paddr`=0.
- R9: With translation off, `user_mode` and `seg_enable` have no effect on any output.
- R10: With `REG_OUT`=1, every output equals the combinational result one clock later. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage and the checks |
| rst_n | input | 1 | Active-low asynchronous reset |
| vaddr | input | 32 | Virtual address |
| user_mode | input | 1 | Access is from user mode |
| xlat_cfg | input | 2 | Translation enable bits; nonzero means on |
| seg_enable | input | 16 | One direct-map enable bit per segment |
| base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| paddr | output | 32 | Physical address, or 0 when paging is requested |
| seg_hit | output | 1 | Direct segment mapping applied |
| page_req | output | 1 | Page translation is needed |
| full_perm | output | 1 | Read, write and execute granted |

## Verification
Two decisions can meet in one cycle. One is the segment enable bit, which grants the direct mapping. The other is the user-mode flag, which forces a page request for the same segment. The bench sweeps every segment with its enable bit both set and clear, against both user-mode values and every configuration value. It then checks that user mode alone withdraws the mapping, and that the disabled configuration overrides both. Each result is compared with an arithmetic model of nibble selection and address concatenation, for the combinational variant and for the registered variant one clock later.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   typedef enum logic [1:0] {
      XK_BYPASS  = 2'd0,
      XK_SEGMENT = 2'd1,
      XK_PAGE    = 2'd2
   } xlate_kind_e;

   typedef struct packed {
      logic seg_hit;
      logic page_req;
      logic full_perm;
   } xlate_flags_t;

   localparam int FLAGS_W = 3;

endpackage

// File: rtl/seg_base_pick.sv
module seg_base_pick #(
   parameter int SEG_W = 4,
   parameter int REG_W = 32
) (
   input  logic [SEG_W-1:0] seg,
   input  logic [REG_W-1:0] base_lo,
   input  logic [REG_W-1:0] base_hi,
   output logic [SEG_W-1:0] base
);
   localparam int NSEG = 1 << SEG_W;
   localparam int HALF = NSEG / 2;

   if (HALF * SEG_W != REG_W) begin : g_bad_pack
      $error("seg_base_pick: base registers must hold exactly half the segment nibbles");
   end

   logic [SEG_W-1:0] nib_tbl [NSEG];

   for (genvar i = 0; i < HALF; i++) begin : g_unpack
      assign nib_tbl[i]        = base_lo[i*SEG_W +: SEG_W];
      assign nib_tbl[i + HALF] = base_hi[i*SEG_W +: SEG_W];
   end

   assign base = nib_tbl[seg];

endmodule

// File: rtl/seg_classify.sv
module seg_classify
   import seg_xlate_pkg::*;
(
   input  logic        xlat_on,
   input  logic        user_mode,
   input  logic        seg_en_bit,
   output xlate_kind_e kind
);
   always_comb begin
      if (!xlat_on)
         kind = XK_BYPASS;
      else if (seg_en_bit && !user_mode)
         kind = XK_SEGMENT;
      else
         kind = XK_PAGE;
   end
endmodule

// File: rtl/seg_out_stage.sv
module seg_out_stage #(
   parameter int W       = 35,
   parameter bit REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("seg_out_stage: width must be positive");
   end

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '0;
         else        q <= d;
      end

      // R10
      reg_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
         rst_n |=> (q == $past(d)));
   end else begin : g_pass
      assign q = d;

      // R10
      pass_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
         q == d);
   end
endmodule

// File: rtl/seg_xlate_top.sv
module seg_xlate_top
   import seg_xlate_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int SEG_W   = 4,
   parameter int CFG_W   = 2,
   parameter bit REG_OUT = 1'b0
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [ADDR_W-1:0]        vaddr,
   input  logic                     user_mode,
   input  logic [CFG_W-1:0]         xlat_cfg,
   input  logic [(1<<SEG_W)-1:0]    seg_enable,
   input  logic [ADDR_W-1:0]        base_lo,
   input  logic [ADDR_W-1:0]        base_hi,
   output logic [ADDR_W-1:0]        paddr,
   output logic                     seg_hit,
   output logic                     page_req,
   output logic                     full_perm
);
   localparam int OFS_W = ADDR_W - SEG_W;
   localparam int OUT_W = ADDR_W + FLAGS_W;

   if (SEG_W < 2 || OFS_W < 1) begin : g_bad_seg
      $error("seg_xlate_top: segment field does not fit the address");
   end
   if (CFG_W < 1) begin : g_bad_cfg
      $error("seg_xlate_top: configuration needs at least one bit");
   end

   logic [SEG_W-1:0]  seg_num;
   logic [SEG_W-1:0]  seg_base;
   logic              xlat_on;
   xlate_kind_e       kind;
   logic [ADDR_W-1:0] paddr_c;
   xlate_flags_t      flags_c;
   xlate_flags_t      flags_q;

   assign seg_num = vaddr[ADDR_W-1 -: SEG_W];
   assign xlat_on = |xlat_cfg;

   seg_base_pick #(.SEG_W(SEG_W), .REG_W(ADDR_W)) u_pick (
      .seg     (seg_num),
      .base_lo (base_lo),
      .base_hi (base_hi),
      .base    (seg_base)
   );

   seg_classify u_cls (
      .xlat_on    (xlat_on),
      .user_mode  (user_mode),
      .seg_en_bit (seg_enable[seg_num]),
      .kind       (kind)
   );

   always_comb begin
      unique case (kind)
         XK_BYPASS: begin
            paddr_c = vaddr;
            flags_c = '{seg_hit: 1'b0, page_req: 1'b0, full_perm: 1'b1};
         end
         XK_SEGMENT: begin
            paddr_c = {seg_base, vaddr[OFS_W-1:0]};
            flags_c = '{seg_hit: 1'b1, page_req: 1'b0, full_perm: 1'b1};
         end
         default: begin
            paddr_c = '0;
            flags_c = '{seg_hit: 1'b0, page_req: 1'b1, full_perm: 1'b0};
         end
      endcase
   end

   seg_out_stage #(.W(OUT_W), .REG_OUT(REG_OUT)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({paddr_c, flags_c}),
      .q     ({paddr, flags_q})
   );

   assign seg_hit   = flags_q.seg_hit;
   assign page_req  = flags_q.page_req;
   assign full_perm = flags_q.full_perm;

   // R1
   bypass_ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_cfg == '0) |-> (paddr_c == vaddr && flags_c.full_perm
                            && !flags_c.seg_hit && !flags_c.page_req));

   // R3
   one_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({flags_c.seg_hit, flags_c.page_req}));

   // R8
   user_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xlat_on && user_mode) |-> (flags_c.page_req && paddr_c == '0
                                  && !flags_c.full_perm));

   // R6
   seg_tail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_c.seg_hit |-> (paddr_c[OFS_W-1:0] == vaddr[OFS_W-1:0]));

   // R7
   seg_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flags_c.seg_hit |-> flags_c.full_perm);

endmodule

// File: tb/tb_seg_xlate_top.sv
`timescale 1ns/1ps
module tb_seg_xlate_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] vaddr = '0;
   logic        user_mode = 1'b0;
   logic [1:0]  xlat_cfg = '0;
   logic [15:0] seg_enable = '0;
   logic [31:0] base_lo = '0;
   logic [31:0] base_hi = '0;

   logic [31:0] pa_c, pa_r;
   logic        sh_c, pr_c, fp_c, sh_r, pr_r, fp_r;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   seg_xlate_top #(.REG_OUT(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .user_mode(user_mode),
      .xlat_cfg(xlat_cfg), .seg_enable(seg_enable), .base_lo(base_lo),
      .base_hi(base_hi), .paddr(pa_c), .seg_hit(sh_c), .page_req(pr_c),
      .full_perm(fp_c));

   seg_xlate_top #(.REG_OUT(1'b1)) dut_reg (
      .clk(clk), .rst_n(rst_n), .vaddr(vaddr), .user_mode(user_mode),
      .xlat_cfg(xlat_cfg), .seg_enable(seg_enable), .base_lo(base_lo),
      .base_hi(base_hi), .paddr(pa_r), .seg_hit(sh_r), .page_req(pr_r),
      .full_perm(fp_r));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   logic [31:0] e_pa;
   logic        e_sh, e_pr, e_fp;
   string       tag;

   task automatic model();
      int seg;
      int nib;
      seg = int'(vaddr[31:28]);                               // R2
      nib = (seg < 8) ? int'((base_lo >> (4*seg)) & 32'hF)    // R4 R5
                      : int'((base_hi >> (4*(seg-8))) & 32'hF);
      if (xlat_cfg == 2'b00) begin
         e_pa = vaddr; e_sh = 0; e_pr = 0; e_fp = 1;
         tag = user_mode ? "R1,R9 bypass" : "R1 bypass";
      end else if (seg_enable[seg] && !user_mode) begin
         e_pa = (nib << 28) + (vaddr & 32'h0FFF_FFFF);
         e_sh = 1; e_pr = 0; e_fp = 1;
         tag = "R2,R3,R4,R5,R6,R7 segment";
      end else begin
         e_pa = 0; e_sh = 0; e_pr = 1; e_fp = 0;
         tag = "R3,R8 page";
      end
   endtask

   initial begin
      logic [31:0] lcg;
      lcg = 32'h1234_5679;
      vaddr = 32'h9ABC_DEF0; xlat_cfg = 2'b11; seg_enable = 16'hFFFF;
      base_lo = 32'h7654_3210; base_hi = 32'hFEDC_BA98;
      repeat (3) @(negedge clk);
      chk("R10 reset paddr", pa_r, 32'h0);
      chk("R10 reset flags", {29'd0, sh_r, pr_r, fp_r}, 32'h0);
      rst_n = 1'b1;
      for (int p = 0; p < 2; p++) begin
         for (int e = 0; e < 2; e++) begin
            for (int c = 0; c < 4; c++) begin
               for (int u = 0; u < 2; u++) begin
                  for (int s = 0; s < 16; s++) begin
                     @(negedge clk);
                     lcg = lcg * 32'd1103515245 + 32'd12345;
                     base_lo    = p ? 32'h3B1F_0E9C : 32'h7654_3210;
                     base_hi    = p ? 32'hA5D2_6487 : 32'hFEDC_BA98;
                     seg_enable = (p ? 16'h5A3C : 16'hA5C3) ^ {16{e[0]}};
                     xlat_cfg   = c[1:0];
                     user_mode  = u[0];
                     vaddr      = {s[3:0], lcg[27:0]};
                     #1;
                     model();
                     chk({tag, " paddr"}, pa_c, e_pa);
                     chk({tag, " flags"}, {29'd0, sh_c, pr_c, fp_c},
                         {29'd0, e_sh, e_pr, e_fp});
                     @(posedge clk); #1;
                     chk({"R10 registered ", tag}, pa_r, e_pa);
                     chk({"R10 registered flags ", tag}, {29'd0, sh_r, pr_r, fp_r},
                         {29'd0, e_sh, e_pr, e_fp});
                  end
               end
            end
         end
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule